// File: doc/BRIEF.md
# ADC Sample-Phase Sequencer

This block is the digital sequencer that times the sample phase of a successive-approximation converter. It counts the sample window in conversion-clock cycles and then a fixed-length convert phase. At the end of a conversion it pulses a result write strobe. The sample window length comes from three settings: a short/long sample select, a 2-bit long-length code and a high-speed flag. In short-sample mode the first conversion of a run is longer than the ones that follow in continuous mode.

The block also handles three ways a conversion can end early. A plain abort leaves the result and the completion flag untouched. A stop request (low-power entry) clears the completion flag and pulses a result-clear strobe. A new start issued mid-conversion restarts the sample window as a first conversion. The conversion-clock request follows the converter's activity unless an always-on enable holds it high.

Top module: `adc_smp_seq`

## Requirements
- R1: With `long_smp_i`=0 and `hs_i`=0, `smp_o` is high for 6 consecutive cycles for a first conversion (single start or first of a run). It is high for 4 cycles for each later conversion of a continuous run. `smp_o` rises in the cycle after `start_i` is sampled.
- R2: With `hs_i`=1 every sample window is 2 cycles longer, so short mode gives 8 cycles (first) and 6 cycles (later).
- R3: With `long_smp_i`=1, `long_sel_i` values 0,1,2,3 give 24, 16, 10 and 6 sample cycles. With `hs_i`=1 these become 26, 18, 12 and 8. The window is the same for first and later conversions.
- R4: `cnv_o` pulses for one cycle, in the cycle after the last sample cycle. The convert phase lasts `CNV_CYC` (default 17) cycles. Then `wr_o` pulses for one cycle, and `done_o` is high from that cycle on.
- R5: If `cont_i` is 1 during the `wr_o` cycle, the next sample window starts in the following cycle with the later-conversion length. If `cont_i` is 0, the block goes idle.
- R6: `abort_i` returns the block to idle in the next cycle without a `wr_o` pulse. It leaves `done_o` unchanged.
- R7: `stop_i` has priority over every other input. In the next cycle the block is idle, `done_o` is 0 and `res_clr_o` is high for exactly one cycle.
- R8: A `start_i` accepted while a conversion is in progress restarts the sample window with the first-conversion length and suppresses the pending write. Any accepted start clears `done_o`. Priority is stop, then abort, then start.
- R9: The sample length is fixed from the settings present in the cycle the conversion starts. Later changes to the settings have no effect on that conversion.
- R10: `clk_req_o` is 1 whenever `async_en_i` is 1. When `async_en_i` is 0, `clk_req_o` is 1 exactly while the block is in a sample, convert or write cycle.
- R11: After reset all outputs are 0 except `clk_req_o`, which equals `async_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin (or restart) a conversion |
| abort_i | input | 1 | Cancel the conversion, keep results |
| stop_i | input | 1 | Low-power stop: cancel and clear results |
| cont_i | input | 1 | Continuous conversion mode |
| long_smp_i | input | 1 | 1 selects long sample mode |
| long_sel_i | input | 2 | Long sample length code |
| hs_i | input | 1 | High-speed mode, lengthens every sample window |
| async_en_i | input | 1 | Keep the clock request on at all times |
| smp_o | output | 1 | Sample window active |
| cnv_o | output | 1 | One-cycle strobe at the start of the convert phase |
| wr_o | output | 1 | One-cycle result register write strobe |
| done_o | output | 1 | Conversion complete flag |
| res_clr_o | output | 1 | One-cycle strobe returning result registers to reset |
| clk_req_o | output | 1 | Conversion clock request |

## Verification
The hardest overlap is a new start that arrives in the same cycle the convert phase ends or the write happens. This is the point where the write strobe and the restarted sample window compete. The bench provokes it with random starts scattered across long runs and a directed restart in mid-sample. Each cycle it compares all outputs with a cycle model that applies the stop, abort, start priority, so a write that leaks past a restart, or a restart that uses the later-conversion length, shows up as a mismatch. Stop and abort colliding with start, and with each other, are judged in the same way.

// File: rtl/adc_smp_pkg.sv
package adc_smp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SMP  = 2'd1,
        PH_CNV  = 2'd2,
        PH_WR   = 2'd3
    } phase_e;

    typedef struct packed {
        logic       long_smp;
        logic [1:0] long_sel;
        logic       hs;
    } smp_cfg_t;

    typedef struct packed {
        phase_e ph;
        logic   done;
        logic   clr;
    } ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_smp_len.sv
module adc_smp_len
    import adc_smp_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int SHORT_BASE  = 4,
    parameter int FIRST_EXTRA = 2,
    parameter int HS_EXTRA    = 2,
    parameter int LONG_L0     = 24,
    parameter int LONG_L1     = 16,
    parameter int LONG_L2     = 10,
    parameter int LONG_L3     = 6
) (
    input  smp_cfg_t         cfg_i,
    input  logic             first_i,
    output logic [CNT_W-1:0] len_o
);

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] hs_add;

    always_comb begin
        if (cfg_i.long_smp) begin
            unique case (cfg_i.long_sel)
                2'd0:    base = CNT_W'(LONG_L0);
                2'd1:    base = CNT_W'(LONG_L1);
                2'd2:    base = CNT_W'(LONG_L2);
                default: base = CNT_W'(LONG_L3);
            endcase
        end else begin
            base = first_i ? CNT_W'(SHORT_BASE + FIRST_EXTRA) : CNT_W'(SHORT_BASE);
        end
        hs_add = cfg_i.hs ? CNT_W'(HS_EXTRA) : '0;
        len_o  = base + hs_add;
    end

endmodule

// File: rtl/adc_smp_cnt.sv
module adc_smp_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/adc_smp_seq.sv
module adc_smp_seq
    import adc_smp_pkg::*;
#(
    parameter int SHORT_BASE  = 4,
    parameter int FIRST_EXTRA = 2,
    parameter int HS_EXTRA    = 2,
    parameter int LONG_L0     = 24,
    parameter int LONG_L1     = 16,
    parameter int LONG_L2     = 10,
    parameter int LONG_L3     = 6,
    parameter int CNV_CYC     = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       abort_i,
    input  logic       stop_i,
    input  logic       cont_i,
    input  logic       long_smp_i,
    input  logic [1:0] long_sel_i,
    input  logic       hs_i,
    input  logic       async_en_i,
    output logic       smp_o,
    output logic       cnv_o,
    output logic       wr_o,
    output logic       done_o,
    output logic       res_clr_o,
    output logic       clk_req_o
);

    localparam int LONG_MAX = max2(max2(LONG_L0, LONG_L1), max2(LONG_L2, LONG_L3));
    localparam int SMP_MAX  = max2(LONG_MAX, SHORT_BASE + FIRST_EXTRA) + HS_EXTRA;
    localparam int CNT_MAX  = max2(SMP_MAX, CNV_CYC);
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    ctl_t             ctl_d, ctl_q;
    smp_cfg_t         cfg_live;
    logic [CNT_W-1:0] smp_len;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             load;
    logic             dec;
    logic             last;

    assign cfg_live = '{long_smp: long_smp_i, long_sel: long_sel_i, hs: hs_i};

    adc_smp_len #(
        .CNT_W      (CNT_W),
        .SHORT_BASE (SHORT_BASE),
        .FIRST_EXTRA(FIRST_EXTRA),
        .HS_EXTRA   (HS_EXTRA),
        .LONG_L0    (LONG_L0),
        .LONG_L1    (LONG_L1),
        .LONG_L2    (LONG_L2),
        .LONG_L3    (LONG_L3)
    ) u_len (
        .cfg_i  (cfg_live),
        .first_i(start_i),
        .len_o  (smp_len)
    );

    adc_smp_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_val_i(load_val),
        .dec_i     (dec),
        .cnt_o     (cnt),
        .last_o    (last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.clr = 1'b0;
        load      = 1'b0;
        load_val  = smp_len;
        dec       = 1'b0;
        if (stop_i) begin
            ctl_d.ph   = PH_IDLE;
            ctl_d.done = 1'b0;
            ctl_d.clr  = 1'b1;
        end else if (abort_i) begin
            ctl_d.ph = PH_IDLE;
        end else if (start_i) begin
            ctl_d.ph   = PH_SMP;
            ctl_d.done = 1'b0;
            load       = 1'b1;
        end else begin
            unique case (ctl_q.ph)
                PH_SMP: begin
                    if (last) begin
                        ctl_d.ph = PH_CNV;
                        load     = 1'b1;
                        load_val = CNT_W'(CNV_CYC);
                    end else begin
                        dec = 1'b1;
                    end
                end
                PH_CNV: begin
                    if (last) begin
                        ctl_d.ph   = PH_WR;
                        ctl_d.done = 1'b1;
                    end else begin
                        dec = 1'b1;
                    end
                end
                PH_WR: begin
                    if (cont_i) begin
                        ctl_d.ph = PH_SMP;
                        load     = 1'b1;
                    end else begin
                        ctl_d.ph = PH_IDLE;
                    end
                end
                default: ctl_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, done: 1'b0, clr: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign smp_o     = (ctl_q.ph == PH_SMP);
    assign cnv_o     = (ctl_q.ph == PH_CNV) && (cnt == CNT_W'(CNV_CYC));
    assign wr_o      = (ctl_q.ph == PH_WR);
    assign done_o    = ctl_q.done;
    assign res_clr_o = ctl_q.clr;
    assign clk_req_o = async_en_i || (ctl_q.ph != PH_IDLE);

endmodule

// File: rtl/adc_smp_seq_chk.sv
module adc_smp_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic abort_i,
    input logic stop_i,
    input logic cont_i,
    input logic async_en_i,
    input logic smp_o,
    input logic cnv_o,
    input logic wr_o,
    input logic done_o,
    input logic res_clr_o,
    input logic clk_req_o
);

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o); // R4
    AST_WR_FLAGS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> done_o); // R4
    AST_CNV_FOLLOWS_SMP: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> $past(smp_o) && !smp_o); // R4
    AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && cont_i && !start_i && !abort_i && !stop_i) |=> smp_o); // R5
    AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !stop_i) |=> !smp_o && !wr_o && (done_o == $past(done_o))); // R6
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> res_clr_o && !done_o && !smp_o && !wr_o); // R7
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_clr_o && !stop_i) |=> !res_clr_o); // R7
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i && !stop_i) |=> smp_o && !done_o && !wr_o); // R8
    AST_CLKREQ_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        async_en_i |-> clk_req_o); // R10
    AST_CLKREQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_o || wr_o || cnv_o) |-> clk_req_o); // R10
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smp_o, wr_o, cnv_o})); // R4

endmodule

bind adc_smp_seq adc_smp_seq_chk u_chk (.*);

// File: tb/adc_smp_seq_bench.sv
module adc_smp_seq_bench;

    localparam int CNV = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       abort_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       cont_i = 1'b0;
    logic       long_smp_i = 1'b0;
    logic [1:0] long_sel_i = 2'd0;
    logic       hs_i = 1'b0;
    logic       async_en_i = 1'b0;
    logic       smp_o, cnv_o, wr_o, done_o, res_clr_o, clk_req_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int m_ph = 0;
    int m_left = 0;
    bit m_done = 1'b0;
    bit m_clr = 1'b0;

    always #4 clk = ~clk;

    adc_smp_seq u_adc_smp_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .abort_i   (abort_i),
        .stop_i    (stop_i),
        .cont_i    (cont_i),
        .long_smp_i(long_smp_i),
        .long_sel_i(long_sel_i),
        .hs_i      (hs_i),
        .async_en_i(async_en_i),
        .smp_o     (smp_o),
        .cnv_o     (cnv_o),
        .wr_o      (wr_o),
        .done_o    (done_o),
        .res_clr_o (res_clr_o),
        .clk_req_o (clk_req_o)
    );

    function automatic int exp_len(bit lg, bit [1:0] sel, bit hs, bit first);
        int b;
        if (lg) begin
            case (sel)
                2'd0: b = 24;
                2'd1: b = 16;
                2'd2: b = 10;
                default: b = 6;
            endcase
        end else begin
            b = first ? 6 : 4;
        end
        return b + (hs ? 2 : 0);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // cycle model built from the requirements
    always @(posedge clk) begin
        m_clr = 1'b0;
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_done = 1'b0;
        end else if (stop_i) begin
            m_ph = 0; m_done = 1'b0; m_clr = 1'b1;
        end else if (abort_i) begin
            m_ph = 0;
        end else if (start_i) begin
            m_ph = 1; m_left = exp_len(long_smp_i, long_sel_i, hs_i, 1'b1); m_done = 1'b0;
        end else begin
            case (m_ph)
                1: if (m_left == 1) begin m_ph = 2; m_left = CNV; end else m_left--;
                2: if (m_left == 1) begin m_ph = 3; m_done = 1'b1; end else m_left--;
                3: if (cont_i) begin
                       m_ph = 1; m_left = exp_len(long_smp_i, long_sel_i, hs_i, 1'b0);
                   end else m_ph = 0;
                default: m_ph = 0;
            endcase
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check(smp_o == (m_ph == 1), "R1/R2/R3 smp_o", smp_o, m_ph == 1);
            check(cnv_o == (m_ph == 2 && m_left == CNV), "R4 cnv_o", cnv_o, m_ph == 2 && m_left == CNV);
            check(wr_o == (m_ph == 3), "R4/R5/R8 wr_o", wr_o, m_ph == 3);
            check(done_o == m_done, "R4/R6/R8 done_o", done_o, m_done);
            check(res_clr_o == m_clr, "R7 res_clr_o", res_clr_o, m_clr);
            check(clk_req_o == (async_en_i || m_ph != 0), "R10 clk_req_o", clk_req_o,
                  async_en_i || m_ph != 0);
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    // first and later sample windows for one setting (R1 R2 R3 R5 R9)
    task automatic run_cfg(bit lg, bit [1:0] sel, bit hs, int e_first, int e_sub, string tag);
        int n;
        step();
        long_smp_i = lg; long_sel_i = sel; hs_i = hs; cont_i = 1'b1; start_i = 1'b1;
        step();
        start_i = 1'b0;
        long_smp_i = ~lg; long_sel_i = ~sel; hs_i = ~hs;
        n = 0;
        while (smp_o) begin n++; step(); end
        check(n == e_first, {tag, " first window, R9 settings held"}, n, e_first);
        long_smp_i = lg; long_sel_i = sel; hs_i = hs;
        while (!wr_o) step();
        step();
        cont_i = 1'b0;
        n = 0;
        while (smp_o) begin n++; step(); end
        check(n == e_sub, {tag, " later window R5"}, n, e_sub);
        while (!wr_o) step();
        step();
        check(!smp_o && !wr_o, "R5 idle after run", smp_o, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step();
        check(!smp_o && !cnv_o && !wr_o && !done_o && !res_clr_o, "R11 reset outputs", smp_o, 0);
        check(clk_req_o == async_en_i, "R11 clk_req reset", clk_req_o, async_en_i);
        rst_n = 1'b1;
        step();

        run_cfg(1'b0, 2'd0, 1'b0, 6, 4, "R1 short");
        run_cfg(1'b0, 2'd0, 1'b1, 8, 6, "R2 short hs");
        run_cfg(1'b1, 2'd0, 1'b0, 24, 24, "R3 long code0");
        run_cfg(1'b1, 2'd1, 1'b0, 16, 16, "R3 long code1");
        run_cfg(1'b1, 2'd2, 1'b0, 10, 10, "R3 long code2");
        run_cfg(1'b1, 2'd3, 1'b0, 6, 6, "R3 long code3");
        run_cfg(1'b1, 2'd0, 1'b1, 26, 26, "R3 long code0 hs");
        run_cfg(1'b1, 2'd3, 1'b1, 8, 8, "R3 long code3 hs");

        // R6: abort while idle keeps the completion flag
        check(done_o == 1'b1, "R4 done held after run", done_o, 1);
        abort_i = 1'b1; step(); abort_i = 1'b0;
        check(done_o == 1'b1, "R6 done kept by abort", done_o, 1);

        // R7: stop clears the flag and pulses the clear strobe once
        stop_i = 1'b1; start_i = 1'b1; step(); stop_i = 1'b0; start_i = 1'b0;
        check(res_clr_o && !done_o && !smp_o, "R7 stop wins", res_clr_o, 1);
        step();
        check(!res_clr_o, "R7 clear pulse single", res_clr_o, 0);

        // R8: restart mid-sample uses the first-conversion length
        long_smp_i = 1'b0; hs_i = 1'b0;
        begin
            int n;
            start_i = 1'b1; step(); start_i = 1'b0;
            step(); step();
            start_i = 1'b1; step(); start_i = 1'b0;
            n = 0;
            while (smp_o) begin n++; step(); end
            check(n == 6, "R8 restart window", n, 6);
            check(!done_o, "R8 done cleared", done_o, 0);
        end
        while (!wr_o) step();
        step();

        // R10 directed
        async_en_i = 1'b1; #1;
        check(clk_req_o, "R10 always-on request", clk_req_o, 1);
        step();
        async_en_i = 1'b0; #1;
        check(!clk_req_o, "R10 idle request low", clk_req_o, 0);

        // random phase, checked each cycle by the model
        for (int i = 0; i < 40000; i++) begin
            step();
            start_i = ($urandom % 40) == 0;
            abort_i = ($urandom % 200) == 0;
            stop_i  = ($urandom % 400) == 0;
            if (($urandom % 100) == 0) cont_i = ~cont_i;
            if (($urandom % 8) == 0) begin
                long_smp_i = 1'($urandom);
                long_sel_i = 2'($urandom);
                hs_i       = 1'($urandom);
            end
            if (($urandom % 300) == 0) async_en_i = 1'($urandom);
        end
        step();
        start_i = 1'b0; abort_i = 1'b0; stop_i = 1'b0;
        repeat (3) step();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule